// File: doc/BRIEF.md
# Pipelined Two-Input Alpha Blender

This block mixes two 12-bit video samples, A and B, into one output sample using a 12-bit weight alpha. The result is alpha·A + (1 − alpha)·B. A new sample pair can enter on every clock. Each pair carries two controls that are captured with it and travel down the pipeline beside it. The first is the number format, which can be unsigned or two's complement. The second is the rounding width of the result. A control change therefore never disturbs samples that are already in flight.

Alpha has its own load enable. When the enable is high, the weight presented on that edge is stored. When it is low, the previously stored weight remains in use. Alpha never exceeds 1.0, so the top bit of the weighted sum carries no information. The output window is therefore taken one bit lower, and the 13-bit result holds the blend with one extra fractional bit. That word is then rounded to 8, 10, 12 or 13 significant bits and saturated.

Top module: `alpha_blend_pipe`

## Requirements
- R1: A sample with `in_valid` high sampled at clock edge n appears on `out_y` with `out_valid` high right after edge n+3, which is four register stages. `out_valid` is low in every cycle that carries no such sample.
- R2: With `fmt_unsigned` = 1, A and B are unsigned values 0..4095.
- R3: With `fmt_unsigned` = 0, A and B are two's complement values −2048..2047, and `out_y` is a two's complement word.
- R4: Alpha is unsigned 1.11 fixed point, so 0x800 is 1.0. Any code above 0x800 is treated as exactly 1.0.
- R5: When `alpha_load` is 1 on an edge, `alpha_in` becomes the weight for the sample captured on that edge and for later samples. When `alpha_load` is 0, the last stored weight is used.
- R6: With rounding code 11, `out_y` is 2·(alpha·A + (1 − alpha)·B), rounded half-up at its LSB. In other words, the sum is shifted left by one bit and its redundant MSB is dropped.
- R7: `rnd_sel` codes 00, 01, 10 and 11 keep the upper 8, 10, 12 and 13 bits of the 13-bit result. Rounding adds half an LSB of the kept width and then clears the discarded low bits to zero.
- R8: A rounded value that exceeds the range of the kept width saturates to its largest or smallest code instead of wrapping.
- R9: `fmt_unsigned` and `rnd_sel` apply only to the sample captured on the same edge. Samples already in flight keep their own settings.
- R10: A synchronous high `rst` clears every stage, `out_valid`, `out_y` and the stored alpha to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample pair on the inputs |
| in_a | input | 12 | Sample A, weighted by alpha |
| in_b | input | 12 | Sample B, weighted by 1 − alpha |
| fmt_unsigned | input | 1 | 1: unsigned inputs, 0: two's complement inputs |
| rnd_sel | input | 2 | Rounding width code for this sample |
| alpha_in | input | 12 | Blend weight, 1.11 fixed point |
| alpha_load | input | 1 | Stores alpha_in on this edge |
| out_valid | output | 1 | Marks a result on out_y |
| out_y | output | 13 | Blended, rounded result |

## Verification
A full cross product is streamed back to back. It covers both formats, all four rounding codes, seven alpha corners and five data corners on each input. The alpha corners include 0, 1.0 and codes above 1.0, which separate a correct weight clamp from a wrapped one. The data corners include the extremes, which separate saturation from wraparound and unsigned from signed extension. A pseudo-random stream then changes format, rounding and the alpha load on every sample and inserts bubbles, which shows that each sample keeps its own controls and the held weight. Directed runs measure the latency of a lone sample and check that a mid-stream reset drops in-flight samples and zeroes the weight.

// File: rtl/alpha_mix_pkg.sv
package alpha_mix_pkg;

    localparam int DATA_W     = 12;
    localparam int ALPHA_W    = 12;
    localparam int ALPHA_FRAC = ALPHA_W - 1;
    localparam int ALPHA_ONE  = 1 << ALPHA_FRAC;
    localparam int OPD_W      = DATA_W + 1;
    localparam int PROD_W     = OPD_W + ALPHA_W + 1;
    localparam int SUM_W      = PROD_W + 1;
    localparam int ADJ_SHIFT  = ALPHA_FRAC - 1;
    localparam int OUT_W      = DATA_W + 1;
    localparam int N_LANES    = 2;

    typedef enum logic [1:0] {
        RND_W8  = 2'b00,
        RND_W10 = 2'b01,
        RND_W12 = 2'b10,
        RND_W13 = 2'b11
    } rnd_mode_e;

    typedef logic signed [OPD_W-1:0]  opd_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic      uns;
        rnd_mode_e rnd;
    } ctl_t;

    typedef struct packed {
        logic vld;
        ctl_t ctl;
        opd_t a;
        opd_t b;
    } cap_t;

    typedef struct packed {
        logic  vld;
        ctl_t  ctl;
        prod_t pa;
        prod_t pb;
    } mul_t;

    typedef struct packed {
        logic vld;
        ctl_t ctl;
        sum_t acc;
    } acc_t;

    function automatic opd_t widen(input logic [DATA_W-1:0] x, input logic uns);
        return uns ? {1'b0, x} : {x[DATA_W-1], x};
    endfunction

    function automatic logic [ALPHA_W-1:0] clip_alpha(input logic [ALPHA_W-1:0] x);
        return (x > ALPHA_W'(ALPHA_ONE)) ? ALPHA_W'(ALPHA_ONE) : x;
    endfunction

    function automatic int drop_bits(input rnd_mode_e m);
        case (m)
            RND_W8:  return OUT_W - 8;
            RND_W10: return OUT_W - 10;
            RND_W12: return OUT_W - 12;
            default: return OUT_W - 13;
        endcase
    endfunction

    function automatic logic [OUT_W-1:0] round_sat(input sum_t s, input ctl_t c);
        longint v;
        longint lim_hi;
        longint lim_lo;
        int     k;
        int     sh;
        k  = drop_bits(c.rnd);
        sh = ADJ_SHIFT + k;
        v  = longint'(s);
        v  = (v + (longint'(1) <<< (sh - 1))) >>> sh;
        if (c.uns) begin
            lim_hi = (longint'(1) <<< (OUT_W - k)) - 1;
            lim_lo = 0;
        end else begin
            lim_hi = (longint'(1) <<< (OUT_W - k - 1)) - 1;
            lim_lo = -(longint'(1) <<< (OUT_W - k - 1));
        end
        if (v > lim_hi) begin
            v = lim_hi;
        end else if (v < lim_lo) begin
            v = lim_lo;
        end
        v = v <<< k;
        return v[OUT_W-1:0];
    endfunction

endpackage

// File: rtl/amx_capture.sv
module amx_capture
    import alpha_mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic               fmt_unsigned,
    input  logic [1:0]         rnd_sel,
    input  logic [ALPHA_W-1:0] alpha_in,
    input  logic               alpha_load,
    output cap_t               cap_q,
    output logic [ALPHA_W-1:0] alpha_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q   <= '0;
            alpha_q <= '0;
        end else begin
            cap_q.vld     <= in_valid;
            cap_q.ctl.uns <= fmt_unsigned;
            cap_q.ctl.rnd <= rnd_mode_e'(rnd_sel);
            cap_q.a       <= widen(in_a, fmt_unsigned);
            cap_q.b       <= widen(in_b, fmt_unsigned);
            if (alpha_load) begin
                alpha_q <= clip_alpha(alpha_in);
            end
        end
    end

endmodule

// File: rtl/amx_weigh.sv
module amx_weigh
    import alpha_mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cap_t               cap_q,
    input  logic [ALPHA_W-1:0] alpha_q,
    output mul_t               mul_q
);

    opd_t               opd  [N_LANES];
    logic [ALPHA_W-1:0] wgt  [N_LANES];
    prod_t              prod [N_LANES];

    assign opd[0] = cap_q.a;
    assign opd[1] = cap_q.b;
    assign wgt[0] = alpha_q;
    assign wgt[1] = ALPHA_W'(ALPHA_ONE) - alpha_q;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign prod[i] = PROD_W'($signed({1'b0, wgt[i]})) * PROD_W'(opd[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_q <= '0;
        end else begin
            mul_q.vld <= cap_q.vld;
            mul_q.ctl <= cap_q.ctl;
            mul_q.pa  <= prod[0];
            mul_q.pb  <= prod[1];
        end
    end

endmodule

// File: rtl/amx_accum.sv
module amx_accum
    import alpha_mix_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  mul_t mul_q,
    output acc_t acc_q
);

    sum_t total;

    assign total = SUM_W'($signed(mul_q.pa)) + SUM_W'($signed(mul_q.pb));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q.vld <= mul_q.vld;
            acc_q.ctl <= mul_q.ctl;
            acc_q.acc <= total;
        end
    end

endmodule

// File: rtl/amx_round.sv
module amx_round
    import alpha_mix_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc_q,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_y
);

    logic [OUT_W-1:0] shaped;

    assign shaped = round_sat(acc_q.acc, acc_q.ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_y     <= '0;
        end else begin
            out_valid <= acc_q.vld;
            out_y     <= shaped;
        end
    end

endmodule

// File: rtl/alpha_blend_pipe.sv
module alpha_blend_pipe
    import alpha_mix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic               fmt_unsigned,
    input  logic [1:0]         rnd_sel,
    input  logic [ALPHA_W-1:0] alpha_in,
    input  logic               alpha_load,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_y
);

    cap_t               cap_q;
    logic [ALPHA_W-1:0] alpha_q;
    mul_t               mul_q;
    acc_t               acc_q;

    amx_capture u_capture (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_a         (in_a),
        .in_b         (in_b),
        .fmt_unsigned (fmt_unsigned),
        .rnd_sel      (rnd_sel),
        .alpha_in     (alpha_in),
        .alpha_load   (alpha_load),
        .cap_q        (cap_q),
        .alpha_q      (alpha_q)
    );

    amx_weigh u_weigh (
        .clk     (clk),
        .rst     (rst),
        .cap_q   (cap_q),
        .alpha_q (alpha_q),
        .mul_q   (mul_q)
    );

    amx_accum u_accum (
        .clk   (clk),
        .rst   (rst),
        .mul_q (mul_q),
        .acc_q (acc_q)
    );

    amx_round u_round (
        .clk       (clk),
        .rst       (rst),
        .acc_q     (acc_q),
        .out_valid (out_valid),
        .out_y     (out_y)
    );

endmodule

// File: rtl/alpha_blend_chk.sv
module alpha_blend_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [11:0] in_a,
    input logic [11:0] in_b,
    input logic        fmt_unsigned,
    input logic [1:0]  rnd_sel,
    input logic        out_valid,
    input logic [12:0] out_y
);

    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc <= '0;
        end else if (cyc != 3'd4) begin
            cyc <= cyc + 3'd1;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4) |-> (out_valid == $past(in_valid, 4)));  // R1

    AST_UNS_EQUAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && $past(in_valid, 4) && $past(fmt_unsigned, 4)
         && $past(rnd_sel, 4) == 2'b11 && $past(in_a, 4) == $past(in_b, 4))
        |-> (out_y == {$past(in_a, 4), 1'b0}));  // R2

    AST_TC_EQUAL_PASS: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && $past(in_valid, 4) && !$past(fmt_unsigned, 4)
         && $past(rnd_sel, 4) == 2'b11 && $past(in_a, 4) == $past(in_b, 4))
        |-> (out_y == {$past(in_a, 4), 1'b0}));  // R3

    AST_LOW_ZERO_W8: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && $past(in_valid, 4) && $past(rnd_sel, 4) == 2'b00)
        |-> (out_y[4:0] == 5'd0));  // R7

    AST_LOW_ZERO_W10: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && $past(in_valid, 4) && $past(rnd_sel, 4) == 2'b01)
        |-> (out_y[2:0] == 3'd0));  // R7

    AST_LOW_ZERO_W12: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && $past(in_valid, 4) && $past(rnd_sel, 4) == 2'b10)
        |-> (out_y[0] == 1'b0));  // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_y == 13'd0));  // R10

endmodule

bind alpha_blend_pipe alpha_blend_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_a         (in_a),
    .in_b         (in_b),
    .fmt_unsigned (fmt_unsigned),
    .rnd_sel      (rnd_sel),
    .out_valid    (out_valid),
    .out_y        (out_y)
);

// File: tb/sim_alpha_blend_pipe.sv
`timescale 1ns/1ps
module sim_alpha_blend_pipe;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_a = '0;
    logic [11:0] in_b = '0;
    logic        fmt_unsigned = 1'b1;
    logic [1:0]  rnd_sel = 2'b11;
    logic [11:0] alpha_in = '0;
    logic        alpha_load = 1'b0;
    logic        out_valid;
    logic [12:0] out_y;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [12:0] exp_q[$];
    string       tag_q[$];
    logic [11:0] held = '0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    alpha_blend_pipe u0 (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_a         (in_a),
        .in_b         (in_b),
        .fmt_unsigned (fmt_unsigned),
        .rnd_sel      (rnd_sel),
        .alpha_in     (alpha_in),
        .alpha_load   (alpha_load),
        .out_valid    (out_valid),
        .out_y        (out_y)
    );

    function automatic logic [12:0] model(input logic [11:0] a, input logic [11:0] b,
                                          input logic [11:0] al, input logic uns,
                                          input logic [1:0] rs);
        longint aa, bb, w, s, num, den, r, hi, lo;
        int     k;
        aa = uns ? longint'(a) : longint'($signed(a));
        bb = uns ? longint'(b) : longint'($signed(b));
        w  = (al > 12'h800) ? 64'sd2048 : longint'(al);
        s  = w * aa + (2048 - w) * bb;
        case (rs)
            2'b00:   k = 5;
            2'b01:   k = 3;
            2'b10:   k = 1;
            default: k = 0;
        endcase
        den = longint'(1) << (10 + k);
        num = s + den / 2;
        r   = num / den;
        if (num < 0 && (num % den) != 0) r = r - 1;
        if (uns) begin
            hi = (longint'(1) << (13 - k)) - 1;
            lo = 0;
        end else begin
            hi = (longint'(1) << (12 - k)) - 1;
            lo = -(longint'(1) << (12 - k));
        end
        if (r > hi) r = hi;
        if (r < lo) r = lo;
        r = r * (longint'(1) << k);
        return r[12:0];
    endfunction

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%h expected 0x%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [11:0] a, input logic [11:0] b, input logic [11:0] al,
                        input logic ld, input logic uns, input logic [1:0] rs,
                        input string tag);
        @(negedge clk);
        in_valid     = 1'b1;
        in_a         = a;
        in_b         = b;
        alpha_in     = al;
        alpha_load   = ld;
        fmt_unsigned = uns;
        rnd_sel      = rs;
        if (ld) held = al;
        exp_q.push_back(model(a, b, held, uns, rs));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            alpha_load = 1'b0;
            alpha_in   = 12'hABC;
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R1: stray out_valid, actual 1 expected 0");
            end else begin
                check(tag_q.pop_front(), out_y, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1: watchdog expired, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] al_set [7];
        logic [11:0] d_set  [5];
        al_set = '{12'h000, 12'h001, 12'h400, 12'h7FF, 12'h800, 12'h801, 12'hFFF};
        d_set  = '{12'h000, 12'h001, 12'h7FF, 12'h800, 12'hFFF};

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state at the outputs
        check("R10 reset valid", {12'd0, out_valid}, 13'd0);
        check("R10 reset data", out_y, 13'd0);

        // R10 R5: stored alpha starts at zero, so output follows B
        send(12'h123, 12'h456, 12'h7FF, 1'b0, 1'b1, 2'b11, "R10 R5 zero alpha");
        idle(6);

        // R1: latency of a lone sample
        send(12'h100, 12'h200, 12'h400, 1'b1, 1'b1, 2'b11, "R1 lone sample");
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                in_valid   = 1'b0;
                alpha_load = 1'b0;
            end
            check($sformatf("R1 valid at cycle %0d", i), {12'd0, out_valid},
                  (i == 4) ? 13'd1 : 13'd0);
        end

        // R2 R3 R4 R6 R7 R8: corner cross product, streamed
        for (int f = 0; f < 2; f++) begin
            for (int rs = 0; rs < 4; rs++) begin
                for (int ai = 0; ai < 7; ai++) begin
                    for (int x = 0; x < 5; x++) begin
                        for (int y = 0; y < 5; y++) begin
                            send(d_set[x], d_set[y], al_set[ai], 1'b1, f[0], rs[1:0],
                                 $sformatf("%s R4 R6 R7 R8 a=%h b=%h al=%h rnd=%0d",
                                           f[0] ? "R2" : "R3",
                                           d_set[x], d_set[y], al_set[ai], rs));
                        end
                    end
                end
            end
        end
        idle(6);

        // R5 R9: controls and alpha load change per sample, with bubbles
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] ra, rb, ral;
            logic        rld, runs, rbub;
            logic [1:0]  rrs;
            seed = next_rand(seed); ra  = seed[27:16];
            seed = next_rand(seed); rb  = seed[27:16];
            seed = next_rand(seed); ral = seed[27:16];
            seed = next_rand(seed);
            rld  = seed[20];
            runs = seed[21];
            rrs  = seed[23:22];
            rbub = (seed[27:24] == 4'd0);
            send(ra, rb, ral, rld, runs, rrs, "R5 R9 random stream");
            if (rbub) idle(1);
        end
        idle(6);

        // R10: reset drops in-flight samples and clears the weight
        send(12'h0FF, 12'h0EE, 12'h600, 1'b1, 1'b1, 2'b11, "R10 dropped");
        send(12'h0DD, 12'h0CC, 12'h600, 1'b1, 1'b1, 2'b11, "R10 dropped");
        @(negedge clk);
        in_valid = 1'b0;
        alpha_load = 1'b0;
        rst = 1'b1;
        exp_q.delete();
        tag_q.delete();
        held = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R10 no output after reset", {12'd0, out_valid}, 13'd0);
        end
        send(12'h321, 12'h654, 12'h800, 1'b0, 1'b1, 2'b11, "R10 R5 weight cleared");
        idle(8);

        // R1: every queued sample came out
        check("R1 outputs pending", 13'(exp_q.size()), 13'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule